// File: doc/BRIEF.md
# Barrel Shift Unit with Status Flags

This block is the shift section of a small processor datapath. It takes a data word and shifts it by an amount of 0 to 31. The shift can be arithmetic right, logical right or logical left. The amount comes from one of two sources: a short immediate, or the low bits of a second register value. Together with the shifted word, the block works out zero, sign, carry and overflow status bits. The result and the flags are written into a registered result word and a registered status word in the same clock edge.

The status word is also shared with the logic operations of the rest of the ALU. A fourth operation kind passes an externally computed logic result through the same register. That kind updates only the zero and sign flags, clears overflow and keeps carry as it was.

Operations are offered with a single-cycle `op_valid` strobe. There is no back-pressure: every strobed operation is accepted. One cycle after the strobe, `res_valid` pulses high for exactly one cycle with the new result and status. Nothing downstream can stall the unit, so any consumer must take the result in that cycle or read it later from the held registers.

Top module: `shift_flag_unit`

## Requirements
- R1: The effective amount n is `amt_imm` when `amt_sel` is 0 and `amt_reg[4:0]` when `amt_sel` is 1. Bits 31:5 of `amt_reg` have no effect on the result or the flags.
- R2: `op_kind` selects the operation:
  - 2'b00 is an arithmetic right shift, which copies operand bit 31 into the vacated bits.
  - 2'b01 is a logical right shift, which fills with zeros.
  - 2'b10 is a left shift, which fills with zeros.
  - 2'b11 is the logic flag update.
- R3: After a shift, status bit 0 (zero) is 1 exactly when the 32-bit result is zero.
- R4: After a shift, status bit 1 (sign) equals bit 31 of the result.
- R5: For either right shift by n ≥ 1, status bit 3 (carry) equals operand bit n-1.
- R6: For a left shift by n ≥ 1, status bit 3 (carry) equals operand bit 32-n.
- R7: Every operation clears status bit 2 (overflow). After a shift, the zero, sign and carry bits depend only on that shift, never on their earlier values.
- R8: A shift by n = 0 returns the operand unchanged and clears carry.
- R9: The logic flag update (kind 2'b11) has these effects:
  - `result` takes the value of `logic_in`.
  - Zero and sign follow that value.
  - Overflow is cleared.
  - Carry is unchanged.
- R10: `result` and `status` change only at the clock edge where `op_valid` is high. `res_valid` is high in the cycle after each strobe and low otherwise. While `op_valid` is low, all outputs hold.
- R11: After reset, `result`, `status` and `res_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_kind | input | 2 | Operation kind (see R2) |
| amt_sel | input | 1 | Amount source: 0 immediate, 1 register |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 32 | Register value supplying the amount in its low 5 bits |
| operand | input | 32 | Word to shift |
| logic_in | input | 32 | Logic result for the flag-update kind |
| result | output | 32 | Registered result word |
| status | output | 4 | Registered flags: bit0 zero, bit1 sign, bit2 overflow, bit3 carry |
| res_valid | output | 1 | High for one cycle after each accepted operation |

## Verification
The assertions assume that `op_kind`, `amt_sel` and the amount inputs are known values whenever `op_valid` is high. They also assume that the strobe is a plain level, sampled at each rising edge, with no further protocol. The bench keeps within this by changing inputs only on falling edges. It drives every field to a defined value before it raises `op_valid`. It holds the strobe for exactly one edge per operation, except in the hold test, where the strobe stays low while the data inputs change.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [1:0] {
    KIND_SAR   = 2'b00,
    KIND_SHR   = 2'b01,
    KIND_SHL   = 2'b10,
    KIND_LOGIC = 2'b11
  } op_kind_e;

  localparam int FLAG_W  = 4;
  localparam int FLAG_Z  = 0;
  localparam int FLAG_S  = 1;
  localparam int FLAG_OV = 2;
  localparam int FLAG_CY = 3;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
  } status_t;

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              amt_sel,
  input  logic [AMT_W-1:0]  amt_imm,
  input  logic [DATA_W-1:0] amt_reg,
  output logic [AMT_W-1:0]  amt
);

  // Upper register bits play no part in the amount.
  logic unused_amt_hi;
  assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

  always_comb begin
    if (amt_sel) amt = amt_reg[AMT_W-1:0];
    else         amt = amt_imm;
  end

endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] shifted,
  output logic              carry_out
);

  // One extra guard bit below the data catches the last bit shifted out.
  localparam int EW = DATA_W + 1;

  logic              go_left;
  logic              fill;
  logic [DATA_W-1:0] reversed_in;
  logic [DATA_W-1:0] oriented;
  logic [DATA_W-1:0] stage_out;
  logic [DATA_W-1:0] reversed_out;
  logic [EW-1:0]     stg [0:AMT_W];

  always_comb begin
    go_left = (kind == KIND_SHL);
    fill    = (kind == KIND_SAR) & operand[DATA_W-1];
    for (int i = 0; i < DATA_W; i++) begin
      reversed_in[i] = operand[DATA_W-1-i];
    end
    oriented = go_left ? reversed_in : operand;
  end

  assign stg[0] = {oriented, 1'b0};

  // Left shifts reuse the right shifter on the bit-reversed word.
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {{SH{fill}}, stg[s][EW-1:SH]} : stg[s];
  end

  assign stage_out = stg[AMT_W][EW-1:1];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      reversed_out[i] = stage_out[DATA_W-1-i];
    end
    shifted   = go_left ? reversed_out : stage_out;
    carry_out = stg[AMT_W][0];
  end

endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] shifted,
  input  logic              carry_out,
  input  logic [DATA_W-1:0] logic_in,
  input  status_t           status_q,
  output logic [DATA_W-1:0] next_result,
  output status_t           next_status
);

  always_comb begin
    next_status.ov = 1'b0;
    if (kind == KIND_LOGIC) begin
      next_result    = logic_in;
      next_status.cy = status_q.cy;
    end else begin
      next_result    = shifted;
      next_status.cy = carry_out;
    end
    next_status.z = (next_result == '0);
    next_status.s = next_result[DATA_W-1];
  end

endmodule

// File: rtl/shift_status_reg.sv
module shift_status_reg
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] next_result,
  input  status_t           next_status,
  output logic [DATA_W-1:0] result_q,
  output status_t           status_q,
  output logic              valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      status_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        result_q <= next_result;
        status_q <= next_status;
      end
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              amt_sel,
  input  logic [AMT_W-1:0]  amt_imm,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] logic_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] status,
  output logic              res_valid
);

  op_kind_e          kind;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;
  logic              carry_out;
  logic [DATA_W-1:0] next_result;
  status_t           next_status;
  status_t           status_q;

  assign kind = op_kind_e'(op_kind);

  shift_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
    .amt_sel (amt_sel),
    .amt_imm (amt_imm),
    .amt_reg (amt_reg),
    .amt     (amt)
  );

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .kind      (kind),
    .operand   (operand),
    .amt       (amt),
    .shifted   (shifted),
    .carry_out (carry_out)
  );

  shift_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .kind        (kind),
    .shifted     (shifted),
    .carry_out   (carry_out),
    .logic_in    (logic_in),
    .status_q    (status_q),
    .next_result (next_result),
    .next_status (next_status)
  );

  shift_status_reg #(.DATA_W(DATA_W)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (op_valid),
    .next_result (next_result),
    .next_status (next_status),
    .result_q    (result),
    .status_q    (status_q),
    .valid_q     (res_valid)
  );

  assign status = status_q;

endmodule

// File: rtl/shift_flag_unit_checker.sv
module shift_flag_unit_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic              amt_sel,
  input logic [AMT_W-1:0]  amt_imm,
  input logic [DATA_W-1:0] amt_reg,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] logic_in,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        status,
  input logic              res_valid
);

  logic [AMT_W-1:0] eff_amt;
  assign eff_amt = amt_sel ? amt_reg[AMT_W-1:0] : amt_imm;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !status[2]);

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (status[0] == (result == '0)));

  assert_sign_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (status[1] == result[DATA_W-1]));

  assert_logic_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'b11) |=> ($stable(status[3]) && result == $past(logic_in)));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(status) && !res_valid));

  assert_valid_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_zero_amount_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != 2'b11 && eff_amt == '0) |=>
      (result == $past(operand) && !status[3]));

endmodule

bind shift_flag_unit shift_flag_unit_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .amt_sel   (amt_sel),
  .amt_imm   (amt_imm),
  .amt_reg   (amt_reg),
  .operand   (operand),
  .logic_in  (logic_in),
  .result    (result),
  .status    (status),
  .res_valid (res_valid)
);

// File: tb/test_shift_flag_unit.sv
`timescale 1ns/1ps
module test_shift_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        amt_sel = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0;
  logic [31:0] operand = '0;
  logic [31:0] logic_in = '0;
  logic [31:0] result;
  logic [3:0]  status;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_flag_unit i_shift_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg),
    .operand(operand), .logic_in(logic_in),
    .result(result), .status(status), .res_valid(res_valid)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: returns {carry, result} from the requirements.
  function automatic logic [32:0] ref_shift(input logic [1:0] k,
                                            input logic [31:0] op,
                                            input int n);
    logic [31:0] r;
    logic c;
    case (k)
      2'b00:   r = 32'($signed(op) >>> n);
      2'b01:   r = op >> n;
      default: r = op << n;
    endcase
    if (n == 0)        c = 1'b0;
    else if (k == 2'b10) c = op[32-n];
    else               c = op[n-1];
    return {c, r};
  endfunction

  // Strobe one operation; return at the next falling edge with outputs registered.
  task automatic do_op(input logic [1:0] k, input logic sel, input logic [4:0] imm,
                       input logic [31:0] areg, input logic [31:0] op,
                       input logic [31:0] lin);
    @(negedge clk);
    op_kind = k; amt_sel = sel; amt_imm = imm; amt_reg = areg;
    operand = op; logic_in = lin; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_shift(input logic [1:0] k, input logic [31:0] op, input int n,
                             input string tag);
    logic [32:0] e;
    e = ref_shift(k, op, n);
    check_eq((n == 0) ? "R8" : "R2", {tag, " result"}, result, e[31:0]);
    check_eq("R3", {tag, " zero"}, 32'(status[0]), 32'(e[31:0] == 0));
    check_eq("R4", {tag, " sign"}, 32'(status[1]), 32'(e[31]));
    check_eq((n == 0) ? "R8" : ((k == 2'b10) ? "R6" : "R5"), {tag, " carry"},
             32'(status[3]), 32'(e[32]));
    check_eq("R7", {tag, " overflow"}, 32'(status[2]), 32'd0);
    check_eq("R10", {tag, " res_valid"}, 32'(res_valid), 32'd1);
  endtask

  task automatic t_reset;
    check_eq("R11", "reset result", result, 32'd0);
    check_eq("R11", "reset status", 32'(status), 32'd0);
    check_eq("R11", "reset res_valid", 32'(res_valid), 32'd0);
  endtask

  task automatic t_sweep;
    logic [31:0] corners [0:4];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h8000_0000;
    corners[2] = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < 32; n++) begin
        corners[3] = $urandom;
        corners[4] = $urandom;
        for (int c = 0; c < 5; c++) begin
          do_op(2'(k), 1'b0, 5'(n), 32'hFFFF_FFE0, corners[c], 32'h0);
          check_shift(2'(k), corners[c], n, "sweep");
        end
      end
    end
  endtask

  task automatic t_amount_reg;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] op;
      int n;
      logic [1:0] k;
      op = $urandom;
      n = i % 32;
      k = 2'(i % 3);
      // R1: upper register bits set; immediate holds a conflicting value.
      do_op(k, 1'b1, 5'(~n), {27'h5A5_A5A5, 5'(n)}, op, 32'h0);
      check_shift(k, op, n, "R1 reg amount");
    end
  endtask

  task automatic t_logic_path;
    // Set carry first: 0x80000000 << 1 gives result 0, carry 1.
    do_op(2'b10, 1'b0, 5'd1, 32'h0, 32'h8000_0000, 32'h0);
    check_eq("R6", "pre carry", 32'(status[3]), 32'd1);
    do_op(2'b11, 1'b0, 5'd3, 32'h0, 32'hFFFF_FFFF, 32'h8000_0001);
    check_eq("R9", "logic result", result, 32'h8000_0001);
    check_eq("R9", "logic status", 32'(status), 32'b1010);
    do_op(2'b11, 1'b0, 5'd0, 32'h0, 32'h1, 32'h0);
    check_eq("R9", "logic zero status", 32'(status), 32'b1001);
    // R7: a shift with no carry-out replaces the old carry and zero.
    do_op(2'b01, 1'b0, 5'd1, 32'h0, 32'h0000_0004, 32'h0);
    check_eq("R7", "replaced status", 32'(status), 32'b0000);
    check_eq("R7", "replaced result", result, 32'h2);
    // Carry clear, then logic keeps it clear.
    do_op(2'b11, 1'b0, 5'd0, 32'h0, 32'h0, 32'h7FFF_0000);
    check_eq("R9", "logic keeps clear carry", 32'(status), 32'b0000);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [3:0]  s0;
    do_op(2'b00, 1'b0, 5'd4, 32'h0, 32'h8000_00F0, 32'h0);
    r0 = result; s0 = status;
    check_eq("R10", "sar result before hold", r0, 32'hF800_000F);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_kind = 2'(i); operand = $urandom; logic_in = $urandom; amt_imm = 5'(i + 1);
      check_eq("R10", "held result", result, r0);
      check_eq("R10", "held status", 32'(status), 32'(s0));
      check_eq("R10", "res_valid low", 32'(res_valid), 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_amount_reg();
    t_logic_path();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule